// File: doc/BRIEF.md
# FFT Stage Sequencer and Buffer Address Generator

This block drives one in-place FFT or IFFT pass over an external buffer whose words each carry four complex points. A 4-bit size code picks the transform length N = 2^code, from 32 up to 4096 points. After a one-cycle start pulse the block walks through every butterfly stage. It issues one point read per clock and sends the matching write to the same buffer slot a fixed number of cycles later, so that a buffer with more than one cycle of read latency can still be used. A last pass re-reads the buffer in bit-reversed order, so that the results leave in natural order. The butterfly arithmetic, the twiddle factors and any real-signal post-processing sit outside this block. It supplies only the addresses, the strobes and the run status.

Radix-4 stages are used: ceil(log2 N / 2) compute stages, where the last one is radix-2 when log2 N is odd. One readout stage follows them. Each stage lasts N issue cycles and then RD_LAT drain cycles, so the pipeline empties before the next stage starts. A one-cycle abort stops the run at once and drops every write that is still in flight.

Top module: `fft_seq_ctrl`

## Requirements
- R1: After reset, ready_o is 1, stage_o and progress_o are 0, and neither mem_rd_o nor mem_wr_o is asserted.
- R2: A start is accepted only when ready_o is 1, en_i is 1 and size_code_i lies in 5..12. With any other code (0..4, 13..15), or with en_i low, ready_o stays 1 and no strobe is issued.
- R3: ready_o drops in the cycle after an accepted start. It stays low for exactly (S+1)·(N+RD_LAT) cycles, where S = ceil(L/2) and L = size code, and it rises in the cycle after the last write.
- R4: In compute stage s (0 ≤ s < S), let w = 1 if s = S−1 and L is odd, and w = 2 otherwise, and let b = L − 2s − w. Stage cycle c < N reads point idx, which is built as follows: the low w bits of c are placed at bit b, and the bits of c>>w fill the other positions in order. The read word is idx[11:2] and the lane is idx[1:0]. One read is issued per cycle for N cycles, and none is issued in the RD_LAT cycles that follow.
- R5: In the readout stage (s = S), cycle c reads point idx = c bit-reversed over L bits, with the same word and lane mapping.
- R6: Each read is followed exactly RD_LAT cycles later by a write to the same word and lane. No other write occurs.
- R7: During a run, stage_o equals the stage number (0..S, where S is the readout stage). progress_o equals the number of reads already issued in the current stage: c in issue cycle c, and N during the drain. Both are 0 in idle.
- R8: The size code and the mode bit are captured on the accepted start. run_inv_o holds the captured mode bit (1 = inverse) for the whole run. Changes on size_code_i, inv_mode_i or en_i during a run have no effect.
- R9: In the cycle after abort_i is high, ready_o is 1, stage_o and progress_o are 0, and no read or write strobe is asserted from then on until a new start.
- R10: A start pulse while ready_o is 0 is ignored: the run keeps its length and its address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Allows a start to be accepted |
| start_i | input | 1 | One-cycle start request |
| abort_i | input | 1 | One-cycle abort; returns to idle |
| size_code_i | input | 4 | log2 of the transform length, valid 5..12 |
| inv_mode_i | input | 1 | 1 = inverse transform, 0 = forward |
| ready_o | output | 1 | High while idle |
| stage_o | output | 3 | Stage in progress; S marks the readout pass |
| progress_o | output | 13 | Reads issued in the current stage |
| run_inv_o | output | 1 | Mode bit captured at start |
| mem_rd_o | output | 1 | Buffer read strobe |
| mem_rd_addr_o | output | 10 | Buffer read word |
| mem_rd_lane_o | output | 2 | Point lane within the read word |
| mem_wr_o | output | 1 | Buffer write strobe, RD_LAT after its read |
| mem_wr_addr_o | output | 10 | Buffer write word |
| mem_wr_lane_o | output | 2 | Point lane within the write word |

## Verification
Every legal size is run once in order, with both mode values. Odd and even log2 N take different last-stage paths (radix-2 against radix-4), so this sweep shows whether the digit placement is right for each. Extra runs on small sizes toggle the size, mode, enable and start inputs at random in every busy cycle. A design that re-samples its inputs or restarts would then change the address stream or the run length. Directed cases send the invalid codes and a start with enable low, which must leave the block idle. An abort is sent with the write pipeline full, and any write that leaks out after the abort cycle is caught.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;
    localparam int FSQ_MAX_LOG = 12;
    localparam int FSQ_MIN_LOG = 5;
    localparam int FSQ_LANE_W  = 2;
    localparam int FSQ_ADDR_W  = FSQ_MAX_LOG - FSQ_LANE_W;
    localparam int FSQ_PROG_W  = FSQ_MAX_LOG + 1;
    localparam int FSQ_STG_W   = 3;
    localparam int FSQ_CODE_W  = 4;

    typedef logic [FSQ_MAX_LOG-1:0] fsq_idx_t;
    typedef logic [FSQ_CODE_W-1:0]  fsq_code_t;
    typedef logic [FSQ_STG_W-1:0]   fsq_stg_t;

    typedef enum logic [1:0] {
        FSQ_IDLE,
        FSQ_ISSUE,
        FSQ_DRAIN
    } fsq_state_e;

    typedef struct packed {
        logic [FSQ_ADDR_W-1:0] word;
        logic [FSQ_LANE_W-1:0] lane;
    } fsq_slot_t;

    function automatic logic fsq_code_ok(fsq_code_t code);
        return (code >= FSQ_CODE_W'(FSQ_MIN_LOG)) && (code <= FSQ_CODE_W'(FSQ_MAX_LOG));
    endfunction

    // compute stages = ceil(log2 N / 2)
    function automatic fsq_stg_t fsq_stage_count(fsq_code_t lg);
        fsq_code_t t;
        t = lg + 1'b1;
        return FSQ_STG_W'(t >> 1);
    endfunction

    // put the low w bits of c at position b; the rest of c fills around it
    function automatic fsq_idx_t fsq_deposit(fsq_idx_t c, int w, int b);
        fsq_idx_t ones, k, lowm, digit;
        ones  = '1;
        k     = c >> w;
        lowm  = ~(ones << b);
        digit = c & ~(ones << w);
        return ((k & ~lowm) << w) | (digit << b) | (k & lowm);
    endfunction

    function automatic fsq_idx_t fsq_bitrev(fsq_idx_t c, fsq_code_t lg);
        fsq_idx_t r;
        for (int i = 0; i < FSQ_MAX_LOG; i++) begin
            r[i] = c[FSQ_MAX_LOG-1-i];
        end
        return r >> (FSQ_MAX_LOG - int'(lg));
    endfunction
endpackage

// File: rtl/fsq_ctrl.sv
`timescale 1ns/1ps
module fsq_ctrl
    import fsq_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  abort_i,
    input  logic                  en_i,
    input  logic                  start_i,
    input  fsq_code_t             code_i,
    input  logic                  inv_i,
    output logic                  ready_o,
    output logic                  rd_v_o,
    output fsq_stg_t              stage_o,
    output logic [FSQ_PROG_W-1:0] cnt_o,
    output fsq_code_t             lg_o,
    output logic                  inv_o
);
    localparam int DCNT_W = (LAT > 1) ? $clog2(LAT) : 1;

    fsq_state_e            state_q;
    fsq_code_t             lg_q;
    logic                  inv_q;
    fsq_stg_t              stage_q;
    logic [FSQ_PROG_W-1:0] cnt_q;
    logic [DCNT_W-1:0]     dcnt_q;
    logic [FSQ_PROG_W-1:0] n_pts;
    fsq_stg_t              n_stg;

    assign n_pts = FSQ_PROG_W'(1) << lg_q;
    assign n_stg = fsq_stage_count(lg_q);

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            state_q <= FSQ_IDLE;
            lg_q    <= '0;
            inv_q   <= 1'b0;
            stage_q <= '0;
            cnt_q   <= '0;
            dcnt_q  <= '0;
        end else begin
            unique case (state_q)
                FSQ_IDLE: begin
                    if (en_i && start_i && fsq_code_ok(code_i)) begin
                        lg_q    <= code_i;
                        inv_q   <= inv_i;
                        stage_q <= '0;
                        cnt_q   <= '0;
                        state_q <= FSQ_ISSUE;
                    end
                end
                FSQ_ISSUE: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == n_pts - 1'b1) begin
                        state_q <= FSQ_DRAIN;
                        dcnt_q  <= '0;
                    end
                end
                FSQ_DRAIN: begin
                    if (dcnt_q == DCNT_W'(LAT - 1)) begin
                        cnt_q <= '0;
                        if (stage_q == n_stg) begin
                            state_q <= FSQ_IDLE;
                            stage_q <= '0;
                        end else begin
                            stage_q <= stage_q + 1'b1;
                            state_q <= FSQ_ISSUE;
                        end
                    end else begin
                        dcnt_q <= dcnt_q + 1'b1;
                    end
                end
                default: state_q <= FSQ_IDLE;
            endcase
        end
    end

    assign ready_o = (state_q == FSQ_IDLE);
    assign rd_v_o  = (state_q == FSQ_ISSUE);
    assign stage_o = stage_q;
    assign cnt_o   = cnt_q;
    assign lg_o    = lg_q;
    assign inv_o   = inv_q;
endmodule

// File: rtl/fsq_agen.sv
`timescale 1ns/1ps
module fsq_agen
    import fsq_pkg::*;
(
    input  fsq_idx_t  cnt_i,
    input  fsq_code_t lg_i,
    input  fsq_stg_t  stage_i,
    output fsq_slot_t slot_o
);
    fsq_stg_t n_stg;
    fsq_idx_t idx;
    int       w;
    int       b;

    assign n_stg = fsq_stage_count(lg_i);

    always_comb begin
        w = 2;
        b = 0;
        if (stage_i == n_stg) begin
            idx = fsq_bitrev(cnt_i, lg_i);
        end else begin
            w   = ((stage_i == n_stg - 3'd1) && lg_i[0]) ? 1 : 2;
            b   = int'(lg_i) - 2 * int'(stage_i) - w;
            idx = fsq_deposit(cnt_i, w, b);
        end
    end

    assign slot_o = fsq_slot_t'(idx);
endmodule

// File: rtl/fsq_pipe.sv
`timescale 1ns/1ps
module fsq_pipe
    import fsq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic      clk,
    input  logic      clear_i,
    input  logic      in_v_i,
    input  fsq_slot_t in_d_i,
    output logic      out_v_o,
    output fsq_slot_t out_d_o
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
        logic      v;
        fsq_slot_t d;
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (clear_i) begin
                    v <= 1'b0;
                    d <= '0;
                end else begin
                    v <= in_v_i;
                    d <= in_d_i;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (clear_i) begin
                    v <= 1'b0;
                    d <= '0;
                end else begin
                    v <= g_tap[i-1].v;
                    d <= g_tap[i-1].d;
                end
            end
        end
    end

    assign out_v_o = g_tap[DEPTH-1].v;
    assign out_d_o = g_tap[DEPTH-1].d;
endmodule

// File: rtl/fft_seq_ctrl.sv
`timescale 1ns/1ps
module fft_seq_ctrl
    import fsq_pkg::*;
#(
    parameter int RD_LAT = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_i,
    input  logic                  start_i,
    input  logic                  abort_i,
    input  logic [FSQ_CODE_W-1:0] size_code_i,
    input  logic                  inv_mode_i,
    output logic                  ready_o,
    output logic [FSQ_STG_W-1:0]  stage_o,
    output logic [FSQ_PROG_W-1:0] progress_o,
    output logic                  run_inv_o,
    output logic                  mem_rd_o,
    output logic [FSQ_ADDR_W-1:0] mem_rd_addr_o,
    output logic [FSQ_LANE_W-1:0] mem_rd_lane_o,
    output logic                  mem_wr_o,
    output logic [FSQ_ADDR_W-1:0] mem_wr_addr_o,
    output logic [FSQ_LANE_W-1:0] mem_wr_lane_o
);
    logic                  rd_v;
    logic                  wr_v;
    fsq_slot_t             rd_slot;
    fsq_slot_t             wr_slot;
    fsq_code_t             lg;
    fsq_stg_t              stage;
    logic [FSQ_PROG_W-1:0] cnt;

    fsq_ctrl #(.LAT(RD_LAT)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .abort_i (abort_i),
        .en_i    (en_i),
        .start_i (start_i),
        .code_i  (size_code_i),
        .inv_i   (inv_mode_i),
        .ready_o (ready_o),
        .rd_v_o  (rd_v),
        .stage_o (stage),
        .cnt_o   (cnt),
        .lg_o    (lg),
        .inv_o   (run_inv_o)
    );

    fsq_agen u_agen (
        .cnt_i   (cnt[FSQ_MAX_LOG-1:0]),
        .lg_i    (lg),
        .stage_i (stage),
        .slot_o  (rd_slot)
    );

    fsq_pipe #(.DEPTH(RD_LAT)) u_pipe (
        .clk     (clk),
        .clear_i (rst | abort_i),
        .in_v_i  (rd_v),
        .in_d_i  (rd_slot),
        .out_v_o (wr_v),
        .out_d_o (wr_slot)
    );

    assign stage_o       = stage;
    assign progress_o    = cnt;
    assign mem_rd_o      = rd_v;
    assign mem_rd_addr_o = rd_slot.word;
    assign mem_rd_lane_o = rd_slot.lane;
    assign mem_wr_o      = wr_v;
    assign mem_wr_addr_o = wr_slot.word;
    assign mem_wr_lane_o = wr_slot.lane;
endmodule

// File: rtl/fsq_chk.sv
`timescale 1ns/1ps
module fsq_chk
    import fsq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  en_i,
    input logic                  start_i,
    input logic                  abort_i,
    input logic [FSQ_CODE_W-1:0] size_code_i,
    input logic                  ready_o,
    input logic [FSQ_STG_W-1:0]  stage_o,
    input logic [FSQ_PROG_W-1:0] progress_o,
    input logic                  run_inv_o,
    input logic                  mem_rd_o,
    input logic [FSQ_ADDR_W-1:0] mem_rd_addr_o,
    input logic                  mem_wr_o,
    input logic [FSQ_ADDR_W-1:0] mem_wr_addr_o
);
    fsq_code_t code_q;
    logic      take;

    assign take = ready_o && en_i && start_i && !abort_i && fsq_code_ok(size_code_i);

    always_ff @(posedge clk) begin
        if (rst) code_q <= 4'(FSQ_MIN_LOG);
        else if (take) code_q <= size_code_i;
    end

    assert_invalid_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i && !abort_i && !fsq_code_ok(size_code_i)) |=> (ready_o && !mem_rd_o));

    assert_ready_drop_R3: assert property (@(posedge clk) disable iff (rst)
        take |=> !ready_o);

    assert_no_read_idle_R4: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !mem_rd_o);

    assert_rd_range_R4: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> (int'(mem_rd_addr_o) < (1 << (int'(code_q) - FSQ_LANE_W))));

    assert_wr_range_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |-> (int'(mem_wr_addr_o) < (1 << (int'(code_q) - FSQ_LANE_W))));

    assert_progress_bound_R7: assert property (@(posedge clk) disable iff (rst)
        !ready_o |-> (int'(progress_o) <= (1 << int'(code_q))));

    assert_idle_stage_R7: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (stage_o == '0 && progress_o == '0));

    assert_mode_held_R8: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && !$past(ready_o)) |-> $stable(run_inv_o));

    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (ready_o && !mem_rd_o && !mem_wr_o && stage_o == '0 && progress_o == '0));
endmodule

bind fft_seq_ctrl fsq_chk u_chk (.*);

// File: tb/sim_fft_seq_ctrl.sv
`timescale 1ns/1ps
module sim_fft_seq_ctrl;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b1;
    logic        start_i = 1'b0;
    logic        abort_i = 1'b0;
    logic [3:0]  size_code_i = 4'd5;
    logic        inv_mode_i = 1'b0;
    logic        ready_o;
    logic [2:0]  stage_o;
    logic [12:0] progress_o;
    logic        run_inv_o;
    logic        mem_rd_o;
    logic [9:0]  mem_rd_addr_o;
    logic [1:0]  mem_rd_lane_o;
    logic        mem_wr_o;
    logic [9:0]  mem_wr_addr_o;
    logic [1:0]  mem_wr_lane_o;

    int tests = 0;
    int fails = 0;
    int bad [8];
    int av  [8];
    int ev  [8];

    always #2.5 clk = ~clk;

    fft_seq_ctrl #(.RD_LAT(LAT)) u0 (.*);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void note(input int k, input int a, input int e);
        if (a != e) begin
            if (bad[k] == 0) begin
                av[k] = a;
                ev[k] = e;
            end
            bad[k]++;
        end
    endfunction

    // expected point index, built bit by bit from the stated ordering
    function automatic int m_idx(input int L, input int st, input int c);
        int S, w, b, k, r;
        S = (L + 1) / 2;
        r = 0;
        if (st == S) begin
            for (int p = 0; p < L; p++) r |= ((c >> (L - 1 - p)) & 1) << p;
        end else begin
            w = (st == S - 1 && (L % 2) == 1) ? 1 : 2;
            b = L - 2 * st - w;
            k = c >> w;
            for (int p = 0; p < L; p++) begin
                if (p < b)          r |= ((k >> p) & 1) << p;
                else if (p < b + w) r |= ((c >> (p - b)) & 1) << p;
                else                r |= ((k >> (p - w)) & 1) << p;
            end
        end
        return r;
    endfunction

    function automatic int rd_now();
        return mem_rd_o ? (4096 | int'({mem_rd_addr_o, mem_rd_lane_o})) : 0;
    endfunction

    function automatic int wr_now();
        return mem_wr_o ? (4096 | int'({mem_wr_addr_o, mem_wr_lane_o})) : 0;
    endfunction

    task automatic do_run(input int code, input bit inv, input bit noisy);
        int L, N, S, per, total;
        L = code; N = 1 << L; S = (L + 1) / 2; per = N + LAT; total = (S + 1) * per;
        for (int k = 0; k < 8; k++) begin bad[k] = 0; av[k] = 0; ev[k] = 0; end
        @(negedge clk);
        en_i = 1'b1; start_i = 1'b1; size_code_i = 4'(code); inv_mode_i = inv;
        @(negedge clk);
        start_i = 1'b0;
        for (int cyc = 0; cyc < total; cyc++) begin
            int st, c, er, ew;
            if (cyc > 0) @(negedge clk);
            st = cyc / per;
            c  = cyc % per;
            er = (c < N)    ? (4096 | m_idx(L, st, c))       : 0;
            ew = (c >= LAT) ? (4096 | m_idx(L, st, c - LAT)) : 0;
            note(0, int'(ready_o), 0);
            note((st == S) ? 6 : 1, rd_now(), er);
            note(2, wr_now(), ew);
            note(3, int'(stage_o), st);
            note(4, int'(progress_o), (c < N) ? c : N);
            note(5, int'(run_inv_o), int'(inv));
            if (noisy && cyc < total - 1) begin
                en_i        = 1'($urandom % 2);
                start_i     = 1'($urandom % 2);
                size_code_i = 4'($urandom % 16);
                inv_mode_i  = 1'($urandom % 2);
            end else begin
                en_i = 1'b1; start_i = 1'b0;
            end
        end
        @(negedge clk);
        note(7, int'(ready_o), 1);
        note(2, wr_now(), 0);
        chk(bad[0] == 0, "R3", $sformatf("ready low while busy, size %0d", code), av[0], ev[0]);
        chk(bad[7] == 0, "R3", $sformatf("ready back after last write, size %0d", code), av[7], ev[7]);
        chk(bad[1] == 0, "R4", $sformatf("compute read order, size %0d", code), av[1], ev[1]);
        chk(bad[6] == 0, "R5", $sformatf("bit-reversed readout, size %0d", code), av[6], ev[6]);
        chk(bad[2] == 0, "R6", $sformatf("delayed writes, size %0d", code), av[2], ev[2]);
        chk(bad[3] == 0, "R7", $sformatf("stage number, size %0d", code), av[3], ev[3]);
        chk(bad[4] == 0, "R7", $sformatf("progress count, size %0d", code), av[4], ev[4]);
        chk(bad[5] == 0, "R8", $sformatf("held mode bit, size %0d", code), av[5], ev[5]);
        if (noisy) begin
            // R10: random start pulses during the run must not alter length or order
            chk(bad[0] == 0 && bad[7] == 0 && bad[1] == 0, "R10",
                $sformatf("start ignored while busy, size %0d", code), bad[0] + bad[1] + bad[7], 0);
        end
    endtask

    task automatic try_reject(input int code, input bit en);
        int leaks;
        leaks = 0;
        @(negedge clk);
        en_i = en; start_i = 1'b1; size_code_i = 4'(code);
        @(negedge clk);
        start_i = 1'b0; en_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (!ready_o || mem_rd_o || mem_wr_o) leaks++;
            @(negedge clk);
        end
        chk(leaks == 0, "R2", $sformatf("start ignored, code %0d en %0d", code, en), leaks, 0);
    endtask

    initial begin
        #1000000;
        tests++;
        fails++;
        $display("FAIL R3 watchdog expired: actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ready_o === 1'b1, "R1", "ready after reset", int'(ready_o), 1);
        chk(stage_o == 3'd0 && progress_o == 13'd0, "R1", "stage and progress after reset",
            int'(stage_o) + int'(progress_o), 0);
        chk(!mem_rd_o && !mem_wr_o, "R1", "no strobes after reset", int'(mem_rd_o) + int'(mem_wr_o), 0);

        // R2 rejected starts
        try_reject(0, 1'b1);
        try_reject(4, 1'b1);
        try_reject(13, 1'b1);
        try_reject(15, 1'b1);
        try_reject(7, 1'b0);

        // every legal size, alternating mode
        for (int code = 5; code <= 12; code++) do_run(code, 1'(code % 2), 1'b0);

        // random sizes with input noise during the run
        for (int i = 0; i < 6; i++) do_run(5 + int'($urandom % 4), 1'($urandom % 2), 1'b1);

        // R9 abort with writes in flight
        begin
            int leaks;
            @(negedge clk);
            en_i = 1'b1; start_i = 1'b1; size_code_i = 4'd8; inv_mode_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (300) @(negedge clk);
            chk(ready_o === 1'b0 && mem_wr_o === 1'b1, "R9", "busy with writes before abort",
                int'(ready_o) * 2 + int'(mem_wr_o), 1);
            abort_i = 1'b1;
            @(negedge clk);
            abort_i = 1'b0;
            chk(ready_o === 1'b1 && stage_o == 3'd0 && progress_o == 13'd0, "R9", "idle state after abort",
                int'(ready_o), 1);
            leaks = 0;
            for (int i = 0; i < LAT + 3; i++) begin
                if (mem_rd_o || mem_wr_o) leaks++;
                @(negedge clk);
            end
            chk(leaks == 0, "R9", "no strobes after abort", leaks, 0);
        end
        do_run(5, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule